// File: doc/BRIEF.md
# Cluster Performance Monitor Counter Unit

This unit counts activity shared by a cluster of processors. A configurable number of 32-bit event counters, and one 64-bit cycle counter, advance on one-cycle pulses from the cluster. The pulses arrive as a vector indexed by event code. Software reaches every counter through a plain register port with a single-cycle write strobe and a combinational read path.

Each event counter is picked through a select register. Once picked, its event code and its value can be read and written. Counter enables, interrupt enables and overflow flags are held in 32-bit bitmaps. Bit i of each bitmap belongs to event counter i, and bit 31 belongs to the cycle counter. A wrap of any counter raises its overflow flag. One level interrupt is driven while an enabled flag is pending. Software reads the overflow word to take the flags, and that same read clears them.

Two event codes have a special meaning. Code 0x11 (clock cycles) is counted only by the cycle counter. Code 0x1E (chain) joins an odd-numbered counter to its even-numbered neighbour, so that the pair acts as one 64-bit event count.

Top module: `cluster_pmu`

## Requirements
- R1: After reset the following hold. The global enable (control register, address 0, bit 0) is clear. All bitmaps and counters are zero. The interrupt output is low. Control bits 15:11 read NUM_CNTR, bits 23:16 read ID_CODE, and bits 31:24 read IMPL_CODE.
- R2: Event counter i adds one for each pulse on the event code held in its type register (address 5, through select register address 4). It counts only when its bit in the counter enable bitmap (address 1) and the global enable are both set.
- R3: The cycle counter is 64 bits wide and is chosen by select value 31. It adds one on every clock while bitmap bit 31 and the global enable are set. Its low word is read at address 6 and its high word at address 7, and a carry passes from the low word into the high word.
- R4: An event counter whose type is 0x11 never counts, even when that pulse arrives.
- R5: An odd-numbered counter of type 0x1E adds one when its even-numbered neighbour wraps.
- R6: A counter that wraps from all-ones to zero sets its flag in the overflow word (address 3). The interrupt output is high while any flag is set together with its bit in the interrupt enable bitmap (address 2).
- R7: A read of address 3 returns the overflow flags and clears them. A wrap in the same cycle as that read leaves its flag set.
- R8: A control write with bit 1 set clears every event counter. A control write with bit 2 set clears the cycle counter. Each leaves the other kind of counter as it was.
- R9: When the select value names no counter (it is at or above NUM_CNTR and is not 31), value and type reads return zero and writes to them are ignored. Bitmap bits of counters that do not exist read zero.
- R10: A write to the value register takes effect on the next cycle. An event pulse that arrives in the same cycle as a write to that counter is lost.
- R11: Addresses 8 and 9 return bits 31:0 and 63:32 of the common-event availability bitmap AVAIL_MASK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe, one cycle |
| reg_rd | input | 1 | Read strobe; it matters only for the read-and-clear at address 3 |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from the address |
| evt_vec | input | NUM_EVT | One-cycle event pulses, indexed by event code |
| irq | output | 1 | Level overflow interrupt |

## Verification
The bench builds the unit with NUM_CNTR set to 4. The select values 4 to 30 therefore name counters that do not exist, so the zero reads and the ignored writes can be checked on select values 4 and 5 and on the bitmap readback. Counters 0 and 1 form an even/odd pair, which brings the chain event within reach. A test-specific AVAIL_MASK gives distinct patterns in both availability words. The cycle counter is preloaded close to its carry point and close to all-ones, so the carry across its 32-bit halves and its full 64-bit wrap are each reached in a single cycle.

// File: rtl/cpmu_pkg.sv
package cpmu_pkg;
    localparam int REG_W      = 32;
    localparam int CYC_IDX    = 31;
    localparam int EVT_CYCLES = 'h11;
    localparam int EVT_CHAIN  = 'h1E;

    typedef enum logic [3:0] {
        RA_CTRL  = 4'd0,
        RA_CNTEN = 4'd1,
        RA_IRQEN = 4'd2,
        RA_OVF   = 4'd3,
        RA_SEL   = 4'd4,
        RA_TYPE  = 4'd5,
        RA_VAL   = 4'd6,
        RA_VALHI = 4'd7,
        RA_AVLO  = 4'd8,
        RA_AVHI  = 4'd9
    } reg_addr_e;
endpackage

// File: rtl/cpmu_evt_cnt.sv
module cpmu_evt_cnt #(
    parameter int NUM_EVT = 64,
    localparam int EVT_W  = $clog2(NUM_EVT)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       count_en,
    input  logic [NUM_EVT-1:0]         evt_vec,
    input  logic                       chain_in,
    input  logic                       clr,
    input  logic                       val_wr,
    input  logic                       type_wr,
    input  logic [cpmu_pkg::REG_W-1:0] wdata,
    output logic [cpmu_pkg::REG_W-1:0] val,
    output logic [EVT_W-1:0]           evt_type,
    output logic                       wrap
);
    typedef struct packed {
        logic [cpmu_pkg::REG_W-1:0] cnt;
        logic [EVT_W-1:0]           typ;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    hit;
    logic    inc;

    always_comb begin
        st_d = st_q;
        if (st_q.typ == EVT_W'(cpmu_pkg::EVT_CHAIN))
            hit = chain_in;
        else
            hit = (st_q.typ != EVT_W'(cpmu_pkg::EVT_CYCLES)) && evt_vec[st_q.typ];
        // pulses are dropped in a cycle that writes or clears the count
        inc  = count_en && hit && !val_wr && !clr;
        wrap = inc && (st_q.cnt == '1);
        if (clr)
            st_d.cnt = '0;
        else if (val_wr)
            st_d.cnt = wdata;
        else if (inc)
            st_d.cnt = st_q.cnt + 1'b1;
        if (type_wr)
            st_d.typ = wdata[EVT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign val      = st_q.cnt;
    assign evt_type = st_q.typ;

    assert_write_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (val_wr && !clr) |=> (val == $past(wdata)));
endmodule

// File: rtl/cpmu_cyc_cnt.sv
module cpmu_cyc_cnt (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       count_en,
    input  logic                       clr,
    input  logic                       wr_lo,
    input  logic                       wr_hi,
    input  logic [cpmu_pkg::REG_W-1:0] wdata,
    output logic [2*cpmu_pkg::REG_W-1:0] val,
    output logic                       wrap
);
    localparam int CW = 2 * cpmu_pkg::REG_W;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } cyc_st_t;

    cyc_st_t st_d, st_q;
    logic    inc;

    always_comb begin
        st_d = st_q;
        inc  = count_en && !clr && !wr_lo && !wr_hi;
        wrap = inc && (st_q.cnt == '1);
        if (clr)
            st_d.cnt = '0;
        else if (wr_lo || wr_hi) begin
            if (wr_lo) st_d.cnt[cpmu_pkg::REG_W-1:0]  = wdata;
            if (wr_hi) st_d.cnt[CW-1:cpmu_pkg::REG_W] = wdata;
        end else if (inc)
            st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign val = st_q.cnt;

    assert_cycle_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (count_en && !clr && !wr_lo && !wr_hi) |=> (val == $past(val) + 64'd1));
endmodule

// File: rtl/cluster_pmu.sv
module cluster_pmu #(
    parameter int          NUM_CNTR   = 6,
    parameter int          NUM_EVT    = 64,
    parameter logic [63:0] AVAIL_MASK = 64'h0000_0000_6A0E_0000,
    parameter logic [7:0]  ID_CODE    = 8'h01,
    parameter logic [7:0]  IMPL_CODE  = 8'h5A
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [3:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic [NUM_EVT-1:0] evt_vec,
    output logic               irq
);
    import cpmu_pkg::*;

    localparam int EVT_W = $clog2(NUM_EVT);
    localparam logic [REG_W-1:0] IMPL_MASK =
        ((32'h1 << NUM_CNTR) - 32'h1) | (32'h1 << CYC_IDX);

    typedef struct packed {
        logic             gen_en;
        logic [REG_W-1:0] cnt_en;
        logic [REG_W-1:0] irq_en;
        logic [REG_W-1:0] ovf;
        logic [4:0]       sel;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [REG_W-1:0]   ev_val  [NUM_CNTR];
    logic [EVT_W-1:0]   ev_type [NUM_CNTR];
    logic [NUM_CNTR-1:0] ev_wrap;
    logic [2*REG_W-1:0] cyc_val;
    logic               cyc_wrap;
    logic [REG_W-1:0]   wrap_vec;

    logic wr_ctrl, clr_ev, clr_cyc, rd_ovf;
    logic cyc_wr_lo, cyc_wr_hi, sel_is_cyc;

    assign wr_ctrl    = reg_wr && (reg_addr == RA_CTRL);
    assign clr_ev     = wr_ctrl && reg_wdata[1];
    assign clr_cyc    = wr_ctrl && reg_wdata[2];
    assign rd_ovf     = reg_rd && (reg_addr == RA_OVF);
    assign sel_is_cyc = (st_q.sel == 5'(CYC_IDX));
    assign cyc_wr_lo  = reg_wr && (reg_addr == RA_VAL) && sel_is_cyc;
    assign cyc_wr_hi  = reg_wr && (reg_addr == RA_VALHI) && sel_is_cyc;

    for (genvar i = 0; i < NUM_CNTR; i++) begin : g_cnt
        logic chain_w;
        logic val_wr_w;
        logic type_wr_w;
        if (i % 2 == 1) begin : g_odd
            assign chain_w = ev_wrap[i-1];
        end else begin : g_even
            assign chain_w = 1'b0;
        end
        assign val_wr_w  = reg_wr && (reg_addr == RA_VAL)  && (st_q.sel == 5'(i));
        assign type_wr_w = reg_wr && (reg_addr == RA_TYPE) && (st_q.sel == 5'(i));

        cpmu_evt_cnt #(.NUM_EVT(NUM_EVT)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .count_en (st_q.gen_en && st_q.cnt_en[i]),
            .evt_vec  (evt_vec),
            .chain_in (chain_w),
            .clr      (clr_ev),
            .val_wr   (val_wr_w),
            .type_wr  (type_wr_w),
            .wdata    (reg_wdata),
            .val      (ev_val[i]),
            .evt_type (ev_type[i]),
            .wrap     (ev_wrap[i])
        );
    end

    cpmu_cyc_cnt u_cyc (
        .clk      (clk),
        .rst_n    (rst_n),
        .count_en (st_q.gen_en && st_q.cnt_en[CYC_IDX]),
        .clr      (clr_cyc),
        .wr_lo    (cyc_wr_lo),
        .wr_hi    (cyc_wr_hi),
        .wdata    (reg_wdata),
        .val      (cyc_val),
        .wrap     (cyc_wrap)
    );

    always_comb begin
        wrap_vec = '0;
        for (int i = 0; i < NUM_CNTR; i++) wrap_vec[i] = ev_wrap[i];
        wrap_vec[CYC_IDX] = cyc_wrap;
    end

    // next state of the control registers
    always_comb begin
        st_d     = st_q;
        st_d.ovf = (rd_ovf ? '0 : st_q.ovf) | wrap_vec;
        if (reg_wr) begin
            case (reg_addr)
                RA_CTRL:  st_d.gen_en = reg_wdata[0];
                RA_CNTEN: st_d.cnt_en = reg_wdata & IMPL_MASK;
                RA_IRQEN: st_d.irq_en = reg_wdata & IMPL_MASK;
                RA_SEL:   st_d.sel    = reg_wdata[4:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // read path
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_CTRL:  reg_rdata = {IMPL_CODE, ID_CODE, 5'(NUM_CNTR), 10'b0, st_q.gen_en};
            RA_CNTEN: reg_rdata = st_q.cnt_en;
            RA_IRQEN: reg_rdata = st_q.irq_en;
            RA_OVF:   reg_rdata = st_q.ovf;
            RA_SEL:   reg_rdata = {27'b0, st_q.sel};
            RA_TYPE: begin
                if (sel_is_cyc) reg_rdata = REG_W'(EVT_CYCLES);
                for (int i = 0; i < NUM_CNTR; i++)
                    if (st_q.sel == 5'(i)) reg_rdata = REG_W'(ev_type[i]);
            end
            RA_VAL: begin
                if (sel_is_cyc) reg_rdata = cyc_val[REG_W-1:0];
                for (int i = 0; i < NUM_CNTR; i++)
                    if (st_q.sel == 5'(i)) reg_rdata = ev_val[i];
            end
            RA_VALHI: if (sel_is_cyc) reg_rdata = cyc_val[2*REG_W-1:REG_W];
            RA_AVLO:  reg_rdata = AVAIL_MASK[31:0];
            RA_AVHI:  reg_rdata = AVAIL_MASK[63:32];
            default:  reg_rdata = '0;
        endcase
    end

    assign irq = |(st_q.ovf & st_q.irq_en);

    assert_cycle_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.gen_en && !clr_cyc && !cyc_wr_lo && !cyc_wr_hi) |=> $stable(cyc_val));

    assert_wrap_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|wrap_vec) |=> ((st_q.ovf & $past(wrap_vec)) == $past(wrap_vec)));

    assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ovf && (wrap_vec == '0)) |=> (st_q.ovf == '0));

    assert_irq_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ovf && (wrap_vec == '0)) |=> !irq);
endmodule

// File: tb/cluster_pmu_tb.sv
module cluster_pmu_tb;
    localparam int          NC   = 4;
    localparam logic [63:0] AV   = 64'h0000_00C3_2E0E_0000;
    localparam logic [7:0]  IDC  = 8'h3C;
    localparam logic [7:0]  IMPC = 8'hA7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [63:0] evt_vec = '0;
    logic        irq;

    int n_chk = 0, n_fail = 0;
    logic [31:0] rv;

    always #10 clk = ~clk;

    cluster_pmu #(.NUM_CNTR(NC), .NUM_EVT(64), .AVAIL_MASK(AV),
                  .ID_CODE(IDC), .IMPL_CODE(IMPC)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .evt_vec(evt_vec), .irq(irq));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic pulse(input int code);
        evt_vec[code] = 1'b1;
        @(negedge clk);
        evt_vec = '0;
    endtask

    task automatic rd_cnt(input int idx, output logic [31:0] d);
        wr(4'd4, 32'(idx));
        rd(4'd6, d);
    endtask

    task automatic t_reset;
        rd(4'd0, rv); chk("R1 ctrl", rv, {IMPC, IDC, 5'(NC), 10'b0, 1'b0});
        chk("R1 irq", 32'(irq), 32'd0);
        rd(4'd1, rv); chk("R1 cnten", rv, 32'd0);
        rd(4'd3, rv); chk("R1 ovf", rv, 32'd0);
        rd_cnt(0, rv); chk("R1 cnt0", rv, 32'd0);
    endtask

    task automatic t_cycle;
        wr(4'd0, 32'h0); wr(4'd1, 32'h8000_0000);
        wr(4'd0, 32'h4);
        wr(4'd0, 32'h1);
        repeat (10) @(negedge clk);
        wr(4'd0, 32'h0);
        rd_cnt(31, rv); chk("R3 cycles lo", rv, 32'd11);
        rd(4'd7, rv); chk("R3 cycles hi", rv, 32'd0);
        wr(4'd6, 32'hFFFF_FFFF); wr(4'd7, 32'h0);
        wr(4'd0, 32'h1); wr(4'd0, 32'h0);
        rd(4'd6, rv); chk("R3 carry lo", rv, 32'd0);
        rd(4'd7, rv); chk("R3 carry hi", rv, 32'd1);
        wr(4'd6, 32'hFFFF_FFFF); wr(4'd7, 32'hFFFF_FFFF);
        wr(4'd0, 32'h1); wr(4'd0, 32'h0);
        rd(4'd7, rv); chk("R3 wrap hi", rv, 32'd0);
        rd(4'd3, rv); chk("R6 cycle wrap flag", rv, 32'h8000_0000);
        rd(4'd3, rv); chk("R7 cleared", rv, 32'd0);
        wr(4'd1, 32'h0);
    endtask

    task automatic t_count;
        wr(4'd4, 32'd0); wr(4'd5, 32'h19); wr(4'd6, 32'd0);
        wr(4'd1, 32'h1); wr(4'd0, 32'h1);
        repeat (3) pulse('h19);
        repeat (2) pulse('h2A);
        rd_cnt(0, rv); chk("R2 counted", rv, 32'd3);
        wr(4'd0, 32'h0); pulse('h19);
        rd_cnt(0, rv); chk("R2 global off", rv, 32'd3);
        wr(4'd0, 32'h1); wr(4'd1, 32'h0); pulse('h19);
        rd_cnt(0, rv); chk("R2 own off", rv, 32'd3);
        rd(4'd5, rv); chk("R2 type readback", rv, 32'h19);
    endtask

    task automatic t_write_drop;
        wr(4'd1, 32'h1); wr(4'd4, 32'd0);
        reg_wr = 1'b1; reg_addr = 4'd6; reg_wdata = 32'd100; evt_vec[8'h19] = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; evt_vec = '0;
        rd(4'd6, rv); chk("R10 write wins", rv, 32'd100);
        pulse('h19);
        rd(4'd6, rv); chk("R10 counts after", rv, 32'd101);
    endtask

    task automatic t_cyc_code;
        wr(4'd4, 32'd1); wr(4'd5, 32'h11); wr(4'd6, 32'd0);
        wr(4'd1, 32'h3);
        repeat (2) pulse('h11);
        rd(4'd6, rv); chk("R4 code 0x11 ignored", rv, 32'd0);
    endtask

    task automatic t_chain_irq;
        wr(4'd4, 32'd0); wr(4'd6, 32'hFFFF_FFFF);
        wr(4'd4, 32'd1); wr(4'd5, 32'h1E); wr(4'd6, 32'd0);
        pulse('h19);
        rd_cnt(0, rv); chk("R5 even wrapped", rv, 32'd0);
        rd_cnt(1, rv); chk("R5 odd chained", rv, 32'd1);
        chk("R6 irq masked", 32'(irq), 32'd0);
        wr(4'd2, 32'h1);
        chk("R6 irq raised", 32'(irq), 32'd1);
        // read overflow in the same cycle as a fresh wrap
        wr(4'd4, 32'd0); wr(4'd6, 32'hFFFF_FFFF);
        reg_rd = 1'b1; reg_addr = 4'd3; evt_vec[8'h19] = 1'b1;
        #1 rv = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0; evt_vec = '0;
        chk("R7 read value", rv, 32'h1);
        rd(4'd3, rv); chk("R7 same-cycle wrap kept", rv, 32'h1);
        rd(4'd3, rv); chk("R7 cleared", rv, 32'h0);
        chk("R7 irq low", 32'(irq), 32'd0);
        wr(4'd2, 32'h0);
    endtask

    task automatic t_resets;
        pulse('h19);
        wr(4'd4, 32'd31); wr(4'd6, 32'h55);
        wr(4'd0, 32'h3);
        rd_cnt(0, rv); chk("R8 ev cleared 0", rv, 32'd0);
        rd_cnt(1, rv); chk("R8 ev cleared 1", rv, 32'd0);
        rd_cnt(31, rv); chk("R8 cycle kept", rv, 32'h55);
        wr(4'd0, 32'h5);
        rd(4'd6, rv); chk("R8 cycle cleared", rv, 32'd0);
        wr(4'd0, 32'h0);
    endtask

    task automatic t_unimpl;
        wr(4'd4, 32'd5); wr(4'd6, 32'h1234); wr(4'd5, 32'h19);
        rd(4'd6, rv); chk("R9 val zero", rv, 32'd0);
        rd(4'd5, rv); chk("R9 type zero", rv, 32'd0);
        wr(4'd4, 32'd4); wr(4'd6, 32'hABCD);
        rd(4'd6, rv); chk("R9 edge index", rv, 32'd0);
        wr(4'd1, 32'hFFFF_FFFF);
        rd(4'd1, rv); chk("R9 bitmap mask", rv, 32'h8000_000F);
        wr(4'd1, 32'h0);
    endtask

    task automatic t_avail;
        rd(4'd8, rv); chk("R11 avail lo", rv, AV[31:0]);
        rd(4'd9, rv); chk("R11 avail hi", rv, AV[63:32]);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_cycle;
        t_count;
        t_write_drop;
        t_cyc_code;
        t_chain_irq;
        t_resets;
        t_unimpl;
        t_avail;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule